// File: doc/BRIEF.md
# Serial Transmitter with Line-Pulse Insertion

This block serialises bytes onto an asynchronous serial line. It has one holding register and two write ports that load it. The data port queues an ordinary character. The second port, the pulse port, changes meaning with the line mode:

- **Plain mode:** the pulse port holds the line at a chosen level for a programmed number of bit times. This is used for break conditions and for gaps between frames.
- **Multidrop mode:** the pulse port sends the byte as an address frame.
- **Infrared mode:** the pulse port behaves as the data port.

The bit time is `baudDiv` clock cycles. A value of 0 is treated as 1, and an even value gives exact half-bit stops.

The holding register moves into the shifter as soon as the shifter is idle. Software can therefore queue one character while another one is on the wire. Status outputs report:

- whether the holding register is empty;
- whether the whole transmitter is empty;
- a one-cycle pulse when a frame's last stop period ends;
- a sticky overrun flag.

Top module: `uart_pulse_tx`

## Requirements
- R1: A data frame is one start bit (logic 0), then 8 data bits least significant bit first, then the stop period (logic 1). Each bit lasts `baudDiv` cycles. The line rests at logic 1 while nothing is being sent.
- R2: The stop period lasts `(twoStop ? 4 : 2) + halfStop` half-bit times, where one half-bit time is `baudDiv/2` cycles.
- R3: When `lineMode` = 1 (multidrop), a ninth bit follows the data bits. It is 0 for a data-port write (`wrSel` = 0) and 1 for a pulse-port write (`wrSel` = 1).
- R4: When `lineMode` = 0 (plain), a pulse-port write drives the line at the level of `wrData[7]` for `wrData[6:0]` bit times. A stop period follows, and no start or data bits are sent.
- R5: When `invertLine` = 1, every line level is inverted. This covers idle, start, data, stop and the pulse level.
- R6: A pulse-port write with a length field of 0 sends only the stop period.
- R7: When `lineMode` = 2 (infrared), a pulse-port write sends the same frame as a data-port write.
- R8: A write through either port that is accepted clears `holdEmpty` in the next cycle. The register moves into an idle shifter one cycle later, which sets `holdEmpty` again.
- R9: `txDone` is high for exactly one cycle, the cycle right after the last stop half-bit ends. `txEmpty` is 1 only when the holding register is empty and the shifter is idle.
- R10: A write while `holdEmpty` is 0 leaves the holding register unchanged and sets `overrun`, which stays set until reset.
- R11: After reset the line is at its idle level, `holdEmpty` and `txEmpty` are 1, and `overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Single-cycle write strobe |
| wrSel | input | 1 | 0 selects the data port, 1 selects the pulse port |
| wrData | input | 8 | Byte written; on the pulse port: bit 7 is the level, bits 6:0 are the length |
| lineMode | input | 2 | 0 plain, 1 multidrop, 2 infrared (3 behaves as 0) |
| baudDiv | input | 16 | Clock cycles per bit time |
| invertLine | input | 1 | Inverts every level driven on the line |
| twoStop | input | 1 | Two stop bits instead of one |
| halfStop | input | 1 | Adds half a bit to the stop period |
| txLine | output | 1 | Serial line |
| holdEmpty | output | 1 | Holding register can take a write |
| txEmpty | output | 1 | Holding register and shifter are both idle |
| txDone | output | 1 | One-cycle pulse at the end of each stop period |
| overrun | output | 1 | Sticky: a write arrived while the holding register was full |

## Verification
The bench targets the cases where the pulse port must not behave like a character:

- **Pulse at the idle level:** a pulse whose level equals the idle level can only be seen through its duration. A design that still sent a start bit, or that ignored the length field, would finish at the wrong cycle.
- **Zero-length pulse:** a design that counted down from zero would wrap and hold the line for 127 bit times.
- **Inverted pulse:** with inversion on, a design that inverted only the character bits would drive the pulse at the wrong level.
- **Ninth bit and stop length:** a multidrop write with the ninth bit taken from the wrong port, or a stop period missing the half-bit extension, would shift the completion pulse by a bit or half-bit time.
- **Back-to-back writes:** a second write in the cycle after the first must be dropped. A design that let it overwrite the holding register would transmit the second byte, or a second frame.

// File: rtl/uart_pulse_tx_pkg.sv
`timescale 1ns/1ps
package uart_pulse_tx_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_MDROP = 2'd1,
    MODE_IRDA  = 2'd2
  } line_mode_e;

  typedef enum logic [1:0] {
    KIND_DATA8 = 2'd0,
    KIND_DATA9 = 2'd1,
    KIND_ADDR9 = 2'd2,
    KIND_PULSE = 2'd3
  } frame_kind_e;

  typedef enum logic [2:0] {
    LVL_IDLE  = 3'd0,
    LVL_START = 3'd1,
    LVL_DATA  = 3'd2,
    LVL_NINTH = 3'd3,
    LVL_PULSE = 3'd4
  } line_sel_e;

  typedef struct packed {
    logic      take;
    logic      shift;
    logic      halfMode;
    logic      frameDone;
    line_sel_e lineSel;
  } tx_strobe_t;

endpackage

// File: rtl/uart_pulse_tx_dp.sv
`timescale 1ns/1ps
module uart_pulse_tx_dp
  import uart_pulse_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        lineMode,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              invertLine,
  input  tx_strobe_t        strobe,
  output logic              holdFull,
  output frame_kind_e       holdKind,
  output logic [DATA_W-2:0] holdLen,
  output logic              tick,
  output logic              txLine,
  output logic              txDone,
  output logic              overrun
);

  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] shiftReg;
  logic              ninthBit;
  logic              pulseLevel;
  logic [DIV_W-1:0]  cycCnt;
  logic [DIV_W-1:0]  divEff;
  logic [DIV_W-1:0]  halfEff;
  logic [DIV_W-1:0]  period;
  logic              accept;
  logic              lineLvl;
  frame_kind_e       newKind;

  assign accept  = wrEn && !holdFull;
  assign holdLen = holdData[DATA_W-2:0];

  always_comb begin
    unique case (line_mode_e'(lineMode))
      MODE_MDROP: newKind = wrSel ? KIND_ADDR9 : KIND_DATA9;
      MODE_IRDA:  newKind = KIND_DATA8;
      default:    newKind = wrSel ? KIND_PULSE : KIND_DATA8;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdData <= '0;
      holdKind <= KIND_DATA8;
      overrun  <= 1'b0;
    end else begin
      if (accept) begin
        holdData <= wrData;
        holdKind <= newKind;
        holdFull <= 1'b1;
      end else if (strobe.take) begin
        holdFull <= 1'b0;
      end
      if (wrEn && holdFull) overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      ninthBit   <= 1'b0;
      pulseLevel <= 1'b1;
    end else if (strobe.take) begin
      shiftReg   <= holdData;
      ninthBit   <= (holdKind == KIND_ADDR9);
      pulseLevel <= holdData[DATA_W-1];
    end else if (strobe.shift) begin
      shiftReg   <= shiftReg >> 1;
    end
  end

  assign divEff  = (baudDiv == '0) ? DIV_W'(1) : baudDiv;
  assign halfEff = ((divEff >> 1) == '0) ? DIV_W'(1) : (divEff >> 1);
  assign period  = strobe.halfMode ? halfEff : divEff;
  assign tick    = (cycCnt >= period - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cycCnt <= '0;
    else if (strobe.take || tick) cycCnt <= '0;
    else                         cycCnt <= cycCnt + DIV_W'(1);
  end

  always_comb begin
    unique case (strobe.lineSel)
      LVL_START: lineLvl = 1'b0;
      LVL_DATA:  lineLvl = shiftReg[0];
      LVL_NINTH: lineLvl = ninthBit;
      LVL_PULSE: lineLvl = pulseLevel;
      default:   lineLvl = 1'b1;
    endcase
  end

  assign txLine = lineLvl ^ invertLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txDone <= 1'b0;
    else       txDone <= strobe.frameDone;
  end

endmodule

// File: rtl/uart_pulse_tx_ctrl.sv
`timescale 1ns/1ps
module uart_pulse_tx_ctrl
  import uart_pulse_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdFull,
  input  frame_kind_e       holdKind,
  input  logic [DATA_W-2:0] holdLen,
  input  logic              tick,
  input  logic              twoStop,
  input  logic              halfStop,
  output tx_strobe_t        strobe,
  output logic              shifterIdle
);

  localparam int UNIT_W = DATA_W;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_NINTH, S_PULSE, S_STOP
  } tx_state_e;

  tx_state_e         state;
  logic [UNIT_W-1:0] unitCnt;
  logic [UNIT_W-1:0] stopHalves;
  logic              hasNinth;
  logic              lastUnit;

  assign stopHalves  = (twoStop ? UNIT_W'(4) : UNIT_W'(2)) + UNIT_W'(halfStop);
  assign lastUnit    = (unitCnt == UNIT_W'(1));
  assign shifterIdle = (state == S_IDLE);

  always_comb begin
    strobe           = '0;
    strobe.take      = (state == S_IDLE) && holdFull;
    strobe.shift     = (state == S_DATA) && tick;
    strobe.halfMode  = (state == S_STOP);
    strobe.frameDone = (state == S_STOP) && tick && lastUnit;
    unique case (state)
      S_START: strobe.lineSel = LVL_START;
      S_DATA:  strobe.lineSel = LVL_DATA;
      S_NINTH: strobe.lineSel = LVL_NINTH;
      S_PULSE: strobe.lineSel = LVL_PULSE;
      default: strobe.lineSel = LVL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      unitCnt  <= '0;
      hasNinth <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (holdFull) begin
          hasNinth <= (holdKind == KIND_DATA9) || (holdKind == KIND_ADDR9);
          if (holdKind != KIND_PULSE) begin
            state <= S_START;
          end else if (holdLen != '0) begin
            state   <= S_PULSE;
            unitCnt <= {1'b0, holdLen};
          end else begin
            state   <= S_STOP;
            unitCnt <= stopHalves;
          end
        end
        S_START: if (tick) begin
          state   <= S_DATA;
          unitCnt <= UNIT_W'(DATA_W);
        end
        S_DATA: if (tick) begin
          if (!lastUnit) begin
            unitCnt <= unitCnt - UNIT_W'(1);
          end else if (hasNinth) begin
            state <= S_NINTH;
          end else begin
            state   <= S_STOP;
            unitCnt <= stopHalves;
          end
        end
        S_NINTH: if (tick) begin
          state   <= S_STOP;
          unitCnt <= stopHalves;
        end
        S_PULSE: if (tick) begin
          if (lastUnit) begin
            state   <= S_STOP;
            unitCnt <= stopHalves;
          end else begin
            unitCnt <= unitCnt - UNIT_W'(1);
          end
        end
        S_STOP: if (tick) begin
          if (lastUnit) state <= S_IDLE;
          else          unitCnt <= unitCnt - UNIT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_pulse_tx.sv
`timescale 1ns/1ps
module uart_pulse_tx
  import uart_pulse_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        lineMode,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              invertLine,
  input  logic              twoStop,
  input  logic              halfStop,
  output logic              txLine,
  output logic              holdEmpty,
  output logic              txEmpty,
  output logic              txDone,
  output logic              overrun
);

  tx_strobe_t        strobe;
  logic              holdFull;
  frame_kind_e       holdKind;
  logic [DATA_W-2:0] holdLen;
  logic              tick;
  logic              shifterIdle;

  uart_pulse_tx_dp #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .lineMode(lineMode), .baudDiv(baudDiv), .invertLine(invertLine),
    .strobe(strobe), .holdFull(holdFull), .holdKind(holdKind), .holdLen(holdLen),
    .tick(tick), .txLine(txLine), .txDone(txDone), .overrun(overrun)
  );

  uart_pulse_tx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .holdFull(holdFull), .holdKind(holdKind),
    .holdLen(holdLen), .tick(tick), .twoStop(twoStop), .halfStop(halfStop),
    .strobe(strobe), .shifterIdle(shifterIdle)
  );

  assign holdEmpty = !holdFull;
  assign txEmpty   = shifterIdle && !holdFull;

endmodule

// File: rtl/uart_pulse_tx_chk.sv
`timescale 1ns/1ps
module uart_pulse_tx_chk #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic [1:0]        lineMode,
  input logic [DIV_W-1:0]  baudDiv,
  input logic              invertLine,
  input logic              twoStop,
  input logic              halfStop,
  input logic              txLine,
  input logic              holdEmpty,
  input logic              txEmpty,
  input logic              txDone,
  input logic              overrun
);

  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> (txLine == !invertLine));

  a_r8_write_fills: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && holdEmpty) |=> !holdEmpty);

  a_r9_empty_needs_hold: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  a_r10_full_write_flags: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !holdEmpty) |=> overrun);

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

endmodule

bind uart_pulse_tx uart_pulse_tx_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .lineMode(lineMode), .baudDiv(baudDiv), .invertLine(invertLine),
  .twoStop(twoStop), .halfStop(halfStop), .txLine(txLine),
  .holdEmpty(holdEmpty), .txEmpty(txEmpty), .txDone(txDone), .overrun(overrun)
);

// File: tb/uart_pulse_tx_tb_top.sv
`timescale 1ns/1ps
module uart_pulse_tx_tb_top;

  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] lineMode = 2'd0;
  logic [15:0] baudDiv = 16'(DIV);
  logic       invertLine = 1'b0;
  logic       twoStop = 1'b0;
  logic       halfStop = 1'b0;
  logic       txLine, holdEmpty, txEmpty, txDone, overrun;

  int  nTests = 0;
  int  nFail  = 0;
  logic lineLog [0:1023];
  int  doneIdx;
  logic holdAt0, emptyAt0, emptyBefore, emptyAtDone;

  uart_pulse_tx dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .lineMode(lineMode), .baudDiv(baudDiv), .invertLine(invertLine),
    .twoStop(twoStop), .halfStop(halfStop), .txLine(txLine),
    .holdEmpty(holdEmpty), .txEmpty(txEmpty), .txDone(txDone), .overrun(overrun)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writePort(input logic sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic capture(input bit skipFirst);
    doneIdx = -1;
    emptyBefore = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      if (!(skipFirst && i == 0)) @(negedge clk);
      lineLog[i] = txLine;
      if (i == 0) begin holdAt0 = holdEmpty; emptyAt0 = txEmpty; end
      if (txDone) begin doneIdx = i; emptyAtDone = txEmpty; break; end
      emptyBefore = txEmpty;
    end
  endtask

  function automatic logic [7:0] dataByte(input logic inv);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[k] = lineLog[(k + 1) * DIV + HALF] ^ inv;
    return b;
  endfunction

  task automatic testReset();
    chk("R11 line idle", txLine, 1);
    chk("R11 holdEmpty", holdEmpty, 1);
    chk("R11 txEmpty", txEmpty, 1);
    chk("R11 overrun", overrun, 0);
  endtask

  task automatic testDataFrame(input logic [7:0] b);
    writePort(1'b0, b);
    chk("R8 holdEmpty low after write", holdEmpty, 0);
    capture(1'b0);
    chk("R8 holdEmpty set on move", holdAt0, 1);
    chk("R9 txEmpty low while sending", emptyAt0, 0);
    chk("R1 start bit", lineLog[HALF], 0);
    chk("R1 data bits", dataByte(1'b0), b);
    chk("R1 stop level", lineLog[9 * DIV + HALF], 1);
    chk("R2 one stop length", doneIdx, 9 * DIV + 2 * HALF);
    chk("R9 txEmpty at done", emptyAtDone, 1);
    chk("R9 txEmpty before done", emptyBefore, 0);
  endtask

  task automatic testStopLengths();
    twoStop = 1'b1; halfStop = 1'b0;
    writePort(1'b0, 8'h3C); capture(1'b0);
    chk("R2 two stop", doneIdx, 9 * DIV + 4 * HALF);
    twoStop = 1'b0; halfStop = 1'b1;
    writePort(1'b0, 8'h3C); capture(1'b0);
    chk("R2 one and a half stop", doneIdx, 9 * DIV + 3 * HALF);
    twoStop = 1'b1; halfStop = 1'b1;
    writePort(1'b0, 8'h3C); capture(1'b0);
    chk("R2 two and a half stop", doneIdx, 9 * DIV + 5 * HALF);
    twoStop = 1'b0; halfStop = 1'b0;
  endtask

  task automatic testMultidrop();
    lineMode = 2'd1;
    writePort(1'b0, 8'h5A); capture(1'b0);
    chk("R3 data byte", dataByte(1'b0), 8'h5A);
    chk("R3 ninth bit data", lineLog[9 * DIV + HALF], 0);
    chk("R3 frame length", doneIdx, 10 * DIV + 2 * HALF);
    writePort(1'b1, 8'h81); capture(1'b0);
    chk("R3 addr byte", dataByte(1'b0), 8'h81);
    chk("R3 ninth bit addr", lineLog[9 * DIV + HALF], 1);
    lineMode = 2'd0;
  endtask

  task automatic testPulses();
    writePort(1'b1, 8'h03);
    chk("R8 pulse port fills hold", holdEmpty, 0);
    capture(1'b0);
    chk("R4 low pulse first", lineLog[0], 0);
    chk("R4 low pulse last", lineLog[3 * DIV - 1], 0);
    chk("R4 stop after pulse", lineLog[3 * DIV], 1);
    chk("R4 pulse length", doneIdx, 3 * DIV + 2 * HALF);
    writePort(1'b1, 8'h82); capture(1'b0);
    chk("R4 high pulse no start", lineLog[HALF], 1);
    chk("R4 high pulse length", doneIdx, 2 * DIV + 2 * HALF);
    writePort(1'b1, 8'h00); capture(1'b0);
    chk("R6 zero length", doneIdx, 2 * HALF);
    chk("R6 line idle", lineLog[0], 1);
  endtask

  task automatic testInverted();
    invertLine = 1'b1;
    @(negedge clk);
    chk("R5 idle inverted", txLine, 0);
    writePort(1'b1, 8'h02); capture(1'b0);
    chk("R5 pulse inverted", lineLog[DIV], 1);
    chk("R5 stop inverted", lineLog[2 * DIV], 0);
    writePort(1'b0, 8'hA5); capture(1'b0);
    chk("R5 start inverted", lineLog[HALF], 1);
    chk("R5 data inverted", dataByte(1'b1), 8'hA5);
    invertLine = 1'b0;
  endtask

  task automatic testIrda();
    lineMode = 2'd2;
    writePort(1'b1, 8'h05); capture(1'b0);
    chk("R7 start bit", lineLog[HALF], 0);
    chk("R7 data byte", dataByte(1'b0), 8'h05);
    chk("R7 frame length", doneIdx, 9 * DIV + 2 * HALF);
    lineMode = 2'd0;
  endtask

  task automatic testOverrun();
    @(negedge clk);
    wrEn = 1'b1; wrSel = 1'b0; wrData = 8'h11;
    @(negedge clk);
    chk("R10 hold full at second write", holdEmpty, 0);
    wrData = 8'hEE;
    @(negedge clk);
    wrEn = 1'b0;
    capture(1'b1);
    chk("R10 first byte kept", dataByte(1'b0), 8'h11);
    chk("R10 overrun set", overrun, 1);
    repeat (3 * DIV) @(negedge clk);
    chk("R10 no second frame", txEmpty, 1);
    chk("R10 overrun sticky", overrun, 1);
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDataFrame(8'hA5);
    testDataFrame(8'h01);
    testStopLengths();
    testMultidrop();
    testPulses();
    testInverted();
    testIrda();
    testOverrun();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule